// File: doc/BRIEF.md
# Variable Page-Size Translation Buffer

This block is a fully associative translation buffer that maps a 40-bit virtual address to a 32-bit physical address. Each of its entries holds a valid bit, a virtual page tag, a physical frame number and a page-size code. The size code decides, entry by entry, where the page number ends and the page offset begins. An entry can describe a 1 KB, 4 KB, 16 KB, 64 KB or 256 KB page.

The lookup port is purely combinational. All entries compare against the presented virtual address in parallel. The block returns hit, miss, a multiple-match error flag, the index of the selected entry and the translated physical address. A controller outside the block loads entries through an indexed write port and can clear single entries through a per-entry invalidate. That controller also handles any miss.

Top module: `vpt_buffer`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until an entry is written.
- R2: A write to an index updates that entry on the next rising clock edge. A lookup in the same cycle as the write sees the old contents.
- R3: Size codes 0, 1, 2, 3 and 4 give offset widths of 10, 12, 14, 16 and 18 bits. An entry matches when virtual address bits [39:offset] equal the same bits of the stored tag placed at bit 10.
- R4: On a hit, physical address bits below the matching entry's offset width equal the same virtual address bits. The bits above come from the stored frame number placed at bit 10.
- R5: An entry whose size code is 5, 6 or 7 never matches.
- R6: An entry whose valid bit is clear never matches. An invalidate clears the selected entry's valid bit at the next rising edge.
- R7: When two or more entries match, lk_multi_o is 1. The index and physical address reported are those of the lowest-index match.
- R8: lk_miss_o is the inverse of lk_hit_o. On a miss, lk_pa_o, lk_idx_o and lk_multi_o are all 0.
- R9: When a write and an invalidate target the same index in the same cycle, the entry ends up invalid.
- R10: A write replaces the tag, frame number and size of the addressed entry and sets its valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_va_i | input | 40 | Lookup virtual address |
| lk_hit_o | output | 1 | At least one valid entry matches |
| lk_miss_o | output | 1 | No entry matches |
| lk_multi_o | output | 1 | More than one entry matches |
| lk_idx_o | output | 5 | Index of the selected (lowest) matching entry |
| lk_pa_o | output | 32 | Translated physical address |
| wr_en_i | input | 1 | Write strobe for one entry |
| wr_idx_i | input | 5 | Entry index to write |
| wr_vpn_i | input | 30 | Virtual tag, virtual address bits [39:10] |
| wr_pfn_i | input | 22 | Frame number, physical address bits [31:10] |
| wr_size_i | input | 3 | Page-size code |
| inv_en_i | input | 1 | Invalidate strobe |
| inv_idx_i | input | 5 | Entry index to invalidate |

## Verification
The bench builds the block with its default parameters: 32 entries, a 40-bit virtual address and a 32-bit physical address. These are the exact widths the size codes were chosen for. Random tags are drawn from a small pool of page bases, so pages of different sizes overlap often. This produces many multiple matches and tests that the lowest index wins. Sizes are drawn across all eight codes, so the reserved codes and every offset split come up often. Directed steps cover a same-cycle write and lookup, and a write colliding with an invalidate.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  localparam int unsigned PG_MIN    = 10;
  localparam int unsigned SZ_W      = 3;
  localparam int unsigned NUM_SIZES = 5;
  localparam int unsigned SZ_STEP   = 2;

  function automatic logic size_ok(input logic [SZ_W-1:0] sz);
    return sz < SZ_W'(NUM_SIZES);
  endfunction

  // extra offset bits above PG_MIN for a size code
  function automatic int unsigned size_shift(input logic [SZ_W-1:0] sz);
    return SZ_STEP * int'(sz);
  endfunction
endpackage

// File: rtl/vpt_entry_bank.sv
module vpt_entry_bank
  import vpt_pkg::*;
#(
  parameter int unsigned N     = 32,
  parameter int unsigned VPN_W = 30,
  parameter int unsigned PFN_W = 22,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [VPN_W-1:0]           wr_vpn_i,
  input  logic [PFN_W-1:0]           wr_pfn_i,
  input  logic [SZ_W-1:0]            wr_size_i,
  input  logic                       inv_en_i,
  input  logic [IDX_W-1:0]           inv_idx_i,
  output logic [N-1:0]               valid_o,
  output logic [N-1:0][VPN_W-1:0]    vpn_o,
  output logic [N-1:0][PFN_W-1:0]    pfn_o,
  output logic [N-1:0][SZ_W-1:0]     size_o
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic wr_hit, inv_hit;
    assign wr_hit  = wr_en_i  && (wr_idx_i  == IDX_W'(i));
    assign inv_hit = inv_en_i && (inv_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      valid_o[i] <= 1'b0;
      else if (inv_hit) valid_o[i] <= 1'b0;  // invalidate wins over write
      else if (wr_hit)  valid_o[i] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (wr_hit) begin
        vpn_o[i]  <= wr_vpn_i;
        pfn_o[i]  <= wr_pfn_i;
        size_o[i] <= wr_size_i;
      end
    end
  end

  p_write_sets_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !(inv_en_i && inv_idx_i == wr_idx_i) |=> valid_o[$past(wr_idx_i)]);
  p_inv_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_en_i |=> !valid_o[$past(inv_idx_i)]);
endmodule

// File: rtl/vpt_match.sv
module vpt_match
  import vpt_pkg::*;
#(
  parameter int unsigned N     = 32,
  parameter int unsigned VPN_W = 30
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [VPN_W-1:0]        va_pg_i,
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][VPN_W-1:0] vpn_i,
  input  logic [N-1:0][SZ_W-1:0]  size_i,
  output logic [N-1:0]            match_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic [VPN_W-1:0] cmp_mask;
    always_comb begin
      cmp_mask   = {VPN_W{1'b1}} << size_shift(size_i[i]);
      match_o[i] = valid_i[i] && size_ok(size_i[i]) &&
                   (((va_pg_i ^ vpn_i[i]) & cmp_mask) == '0);
    end

    p_reserved_no_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !size_ok(size_i[i]) |-> !match_o[i]);
  end

  p_match_needs_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o & ~valid_i) == '0);
endmodule

// File: rtl/vpt_select.sv
module vpt_select
  import vpt_pkg::*;
#(
  parameter int unsigned N     = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned PFN_W = 22,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N-1:0]            match_i,
  input  logic [N-1:0][PFN_W-1:0] pfn_i,
  input  logic [N-1:0][SZ_W-1:0]  size_i,
  input  logic [PA_W-1:0]         va_low_i,
  output logic                    hit_o,
  output logic                    miss_o,
  output logic                    multi_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [PA_W-1:0]         pa_o
);
  logic [PA_W-1:0] off_mask;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o   = |match_i;
  assign miss_o  = ~hit_o;
  assign multi_o = (match_i & (match_i - N'(1))) != '0;

  always_comb begin
    off_mask = (PA_W'(1) << (PG_MIN + size_shift(size_i[idx_o]))) - PA_W'(1);
    if (hit_o) pa_o = ({pfn_i[idx_o], {PG_MIN{1'b0}}} & ~off_mask) | (va_low_i & off_mask);
    else       pa_o = '0;
  end

  p_multi_implies_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o |-> hit_o);
  p_lowest_selected_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> match_i[idx_o] && ((match_i & ((N'(1) << idx_o) - N'(1))) == '0));
  p_miss_outputs_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> !hit_o && pa_o == '0 && idx_o == '0 && !multi_o);
endmodule

// File: rtl/vpt_buffer.sv
module vpt_buffer
  import vpt_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 32,
  parameter int unsigned VA_W      = 40,
  parameter int unsigned PA_W      = 32,
  localparam int unsigned IDX_W = $clog2(N_ENTRIES),
  localparam int unsigned VPN_W = VA_W - PG_MIN,
  localparam int unsigned PFN_W = PA_W - PG_MIN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VA_W-1:0]  lk_va_i,
  output logic             lk_hit_o,
  output logic             lk_miss_o,
  output logic             lk_multi_o,
  output logic [IDX_W-1:0] lk_idx_o,
  output logic [PA_W-1:0]  lk_pa_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PFN_W-1:0] wr_pfn_i,
  input  logic [SZ_W-1:0]  wr_size_i,
  input  logic             inv_en_i,
  input  logic [IDX_W-1:0] inv_idx_i
);
  logic [N_ENTRIES-1:0]            valid, match;
  logic [N_ENTRIES-1:0][VPN_W-1:0] vpn;
  logic [N_ENTRIES-1:0][PFN_W-1:0] pfn;
  logic [N_ENTRIES-1:0][SZ_W-1:0]  size;

  vpt_entry_bank #(.N(N_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_bank (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_vpn_i, .wr_pfn_i, .wr_size_i,
    .inv_en_i, .inv_idx_i,
    .valid_o(valid), .vpn_o(vpn), .pfn_o(pfn), .size_o(size)
  );

  vpt_match #(.N(N_ENTRIES), .VPN_W(VPN_W)) u_match (
    .clk_i, .rst_ni, .va_pg_i(lk_va_i[VA_W-1:PG_MIN]),
    .valid_i(valid), .vpn_i(vpn), .size_i(size), .match_o(match)
  );

  vpt_select #(.N(N_ENTRIES), .PA_W(PA_W), .PFN_W(PFN_W)) u_sel (
    .clk_i, .rst_ni, .match_i(match), .pfn_i(pfn), .size_i(size),
    .va_low_i(lk_va_i[PA_W-1:0]),
    .hit_o(lk_hit_o), .miss_o(lk_miss_o), .multi_o(lk_multi_o),
    .idx_o(lk_idx_o), .pa_o(lk_pa_o)
  );

  p_hit_miss_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o != lk_miss_o);
  p_no_hit_after_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> lk_miss_o);
endmodule

// File: tb/vpt_buffer_test.sv
module vpt_buffer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [39:0] va;
  logic hit, miss, multi;
  logic [4:0] idx;
  logic [31:0] pa;
  logic wr_en = 0, inv_en = 0;
  logic [4:0] wr_idx = 0, inv_idx = 0;
  logic [29:0] wr_vpn = 0;
  logic [21:0] wr_pfn = 0;
  logic [2:0] wr_size = 0;

  vpt_buffer uut (
    .clk_i(clk), .rst_ni(rst_n), .lk_va_i(va), .lk_hit_o(hit), .lk_miss_o(miss),
    .lk_multi_o(multi), .lk_idx_o(idx), .lk_pa_o(pa), .wr_en_i(wr_en),
    .wr_idx_i(wr_idx), .wr_vpn_i(wr_vpn), .wr_pfn_i(wr_pfn), .wr_size_i(wr_size),
    .inv_en_i(inv_en), .inv_idx_i(inv_idx)
  );

  // behavioural reference state
  bit          m_v   [32];
  logic [29:0] m_vpn [32];
  logic [21:0] m_pfn [32];
  int          m_sz  [32];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int nm = 0, first = -1;
    logic [31:0] epa = '0;
    for (int i = 0; i < 32; i++) begin
      if (m_v[i] && m_sz[i] < 5) begin
        int off = 10 + 2 * m_sz[i];
        logic [39:0] base = {m_vpn[i], 10'b0};
        if ((va >> off) == (base >> off)) begin
          nm++;
          if (first < 0) first = i;
        end
      end
    end
    if (first >= 0) begin
      logic [31:0] msk = (32'd1 << (10 + 2 * m_sz[first])) - 1;
      epa = ({m_pfn[first], 10'b0} & ~msk) | (va[31:0] & msk);
    end
    chk(tag, "hit", hit, nm > 0);
    chk(tag, "miss", miss, nm == 0);
    chk(tag, "multi", multi, nm > 1);
    chk(tag, "idx", idx, first < 0 ? 0 : first);
    chk(tag, "pa", pa, epa);
  endtask

  task automatic step(bit we, int wi, logic [29:0] vp, logic [21:0] pf, int sz,
                      bit ie, int ii, logic [39:0] a, string tag);
    @(negedge clk);
    wr_en = we; wr_idx = 5'(wi); wr_vpn = vp; wr_pfn = pf; wr_size = 3'(sz);
    inv_en = ie; inv_idx = 5'(ii); va = a;
    #1 compare(tag);
    @(posedge clk);
    if (we) begin m_v[wi] = 1; m_vpn[wi] = vp; m_pfn[wi] = pf; m_sz[wi] = sz; end
    if (ie) m_v[ii] = 0;
  endtask

  function automatic logic [39:0] va_in(logic [29:0] vp, int sz, logic [39:0] r);
    logic [39:0] m = (40'd1 << (10 + 2 * (sz % 5))) - 1;
    return ({vp, 10'b0} & ~m) | (r & m);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [29:0] pool [4];
    va = 40'h12_3456_7890;
    for (int i = 0; i < 32; i++) m_v[i] = 0;
    repeat (3) @(posedge clk);
    #1 compare("R1");
    rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 0, 40'hFF_FFFF_FC00, "R1");
    // write entry 3 (4 KB), same-cycle lookup must miss
    step(1, 3, 30'h0ABC_DE40, 22'h2A_5A5, 1, 0, 0, va_in(30'h0ABC_DE40, 1, 40'h5A7), "R2");
    step(0, 0, 0, 0, 0, 0, 0, va_in(30'h0ABC_DE40, 1, 40'hFFF), "R2 R3 R4");
    step(0, 0, 0, 0, 0, 0, 0, va_in(30'h0ABC_DE40, 1, 40'h1000), "R3");
    // 256 KB entry 7 overlapping entry 3
    step(1, 7, 30'h0ABC_DE00, 22'h11_1111, 4, 0, 0, 40'h0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, va_in(30'h0ABC_DE40, 1, 40'h123), "R7");
    step(0, 0, 0, 0, 0, 0, 0, va_in(30'h0ABC_DE00, 4, 40'h3_FFFF), "R3 R4");
    // reserved size
    step(1, 9, 30'h1234_5670, 22'h3F_FFFF, 5, 0, 0, 40'h0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, va_in(30'h1234_5670, 0, 40'h0), "R5");
    // invalidate entry 3
    step(0, 0, 0, 0, 0, 1, 3, va_in(30'h0ABC_DE40, 1, 40'h1), "R7");
    step(0, 0, 0, 0, 0, 0, 0, va_in(30'h0ABC_DE40, 1, 40'h1), "R6");
    // collision of write and invalidate
    step(1, 3, 30'h0ABC_DE40, 22'h2A_5A5, 1, 1, 3, 40'h0, "R9");
    step(0, 0, 0, 0, 0, 0, 0, va_in(30'h0ABC_DE40, 1, 40'h2), "R9");
    // overwrite entry 7 with a 1 KB page
    step(1, 7, 30'h0000_0011, 22'h00_0022, 0, 0, 0, 40'h0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, va_in(30'h0ABC_DE00, 4, 40'h400), "R10");
    step(0, 0, 0, 0, 0, 0, 0, va_in(30'h0000_0011, 0, 40'h3FF), "R10");
    // random phase
    for (int p = 0; p < 4; p++) pool[p] = 30'($urandom);
    for (int n = 0; n < 3000; n++) begin
      int wi = $urandom_range(0, 31);
      int sz = $urandom_range(0, 7);
      logic [29:0] vp = pool[$urandom_range(0, 3)] ^ 30'($urandom_range(0, 1023));
      logic [39:0] a = va_in(pool[$urandom_range(0, 3)] ^ 30'($urandom_range(0, 1023)),
                             $urandom_range(0, 4), {$urandom, $urandom});
      step($urandom_range(0, 3) == 0, wi, vp, 22'($urandom), sz,
           $urandom_range(0, 7) == 0, $urandom_range(0, 31), a, "R3 R4 R6 R7 R8");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule